// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Controller

This block decides when an 8-bit microcontroller core takes an interrupt and where it jumps. Time is counted in machine cycles. The core marks each one with a single-clock strobe at its late sampling point. At every strobe the controller captures the raw request flags into a latch, whatever else is in progress. The poll made at a strobe only sees what the latch captured at the previous strobe.

A poll finds the pending, enabled request that wins. A high-level request beats any low-level one, and a fixed order settles ties within a level. The poll then checks two things. It does not take the request if the core is in the last machine cycle of an instruction that touches the enable or level registers, or of a return-from-interrupt. It also does not take a request whose level is not above the service routine now running. If either check fails, the attempt is dropped and the latch is polled again at the next strobe.

An accepted request starts a long call that lasts two machine cycles. The call request and the 16-bit vector are driven during both. A one-hot acknowledge for the serviced source is driven during the second, so the peripheral can clear its flag. A two-entry stack tracks the levels of the routines in service. The stack is pushed when the call ends and popped when a return-from-interrupt completes.

Top module: `vic_ack_ctrl`

## Requirements
- R1: During and right after a synchronous reset, `call_req` is 0, `ack` is 0, `vector` is 0 and the in-service stack is empty.
- R2: Raw flags are captured only at a strobe. A flag that is high at a strobe is serviced even if it falls right afterwards. A flag pulse that rises and falls between two strobes has no effect.
- R3: A flag captured at strobe n is polled at strobe n+1. If accepted, `call_req` is high from strobe n+1 to strobe n+3. `ack` is 0 in the first call cycle and holds the one-hot source from strobe n+2 to strobe n+3. No acknowledge is pending outside a call.
- R4: Vectors by source: external 0 gives 0x0003, timer 0 gives 0x000B, external 1 gives 0x0013, timer 1 gives 0x001B, serial gives 0x0023 and power-fail gives 0x002B. `vector` holds its value for the whole call.
- R5: The serial source is pending when the receive flag (`irq_raw[4]`), the transmit flag (`irq_raw[5]`) or both are set. It is acknowledged on `ack[5]`.
- R6: A source is taken only if both its bit in `src_en` and `glb_en` are 1.
- R7: A source with its `src_hi` bit set beats any source with that bit clear. Within a level, the order is power-fail, external 0, timer 0, external 1, timer 1, serial. Source index order for `src_en`, `src_hi` and `ack` is: 0 power-fail, 1 external 0, 2 timer 0, 3 external 1, 4 timer 1, 5 serial.
- R8: A poll in a machine cycle where `instr_last` is high together with `regs_touch` or `reti_exec` starts no call. The request is polled again at the next strobe.
- R9: While a low-level routine is in service, only high-level requests are taken. While a high-level routine is in service, nothing is taken. A strobe with `reti_exec` and `instr_last` both high pops one level.
- R10: Capture goes on during a call. A request that arrives during the call is polled at the first strobe after the call ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cyc_stb | input | 1 | one-clock strobe at the sampling point of each machine cycle |
| irq_raw | input | 7 | raw flags: 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial rx, 5 serial tx, 6 power-fail |
| src_en | input | 6 | per-source enable, source index order |
| glb_en | input | 1 | global enable |
| src_hi | input | 6 | per-source high level, source index order |
| instr_last | input | 1 | current machine cycle is the last of an instruction |
| regs_touch | input | 1 | current instruction accesses the enable or level registers |
| reti_exec | input | 1 | current instruction is a return-from-interrupt |
| call_req | output | 1 | long call in progress |
| vector | output | 16 | target address of the call |
| ack | output | 6 | one-hot acknowledge during the second call cycle |

## Verification
Capture and call sequencing overlap in time. A new request can be latched while a long call is still running. The bench provokes this by raising a high-level power-fail flag during the first call cycle of a low-level external-1 service. It then expects `call_req` low for exactly one strobe after the call and a new call to 0x002B at the next strobe. This shows that the flag was captured during the call and that its higher level passes the in-service check. A second overlap is a return-from-interrupt pop in the same cycle as a poll. That poll must be blocked, and the request must be taken one strobe later.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC  = 6;
  localparam int NRAW  = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CALL1 = 2'd1,
    ST_CALL2 = 2'd2
  } ack_st_t;

  // vector slot of a source index: power-fail (index 0) sits at the last slot
  function automatic int slot_of(input int idx);
    return (idx == 0) ? NSRC - 1 : idx - 1;
  endfunction
endpackage

// File: rtl/vic_latch.sv
module vic_latch
  import vic_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            stb,
  input  logic [NRAW-1:0] raw,
  output logic [NSRC-1:0] lat
);
  logic [NSRC-1:0] src_now;

  // map raw flag positions to source index order; serial is rx OR tx
  always_comb begin
    src_now[0] = raw[6];
    src_now[1] = raw[0];
    src_now[2] = raw[1];
    src_now[3] = raw[2];
    src_now[4] = raw[3];
    src_now[5] = raw[4] | raw[5];
  end

  always_ff @(posedge clk) begin
    if (rst)      lat <= '0;
    else if (stb) lat <= src_now;
  end

  p_latch_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(lat));
endmodule

// File: rtl/vic_arb.sv
module vic_arb
  import vic_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] hi,
  output logic [NSRC-1:0] win_oh,
  output logic            win_hi,
  output logic            any
);
  logic [NSRC-1:0] hi_req;
  logic [NSRC-1:0] pool;

  assign hi_req = pend & hi;
  assign pool   = (|hi_req) ? hi_req : pend;
  assign any    = |pend;
  assign win_hi = |hi_req;

  // fixed order: lowest index wins
  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_pick
      if (g == 0) begin : g_first
        assign win_oh[g] = pool[g];
      end else begin : g_rest
        assign win_oh[g] = pool[g] & ~(|pool[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    p_grant_onehot_r7: assert ($onehot0(win_oh));
    p_grant_any_r7:    assert ((|win_oh) == any);
  end
endmodule

// File: rtl/vic_svc.sv
module vic_svc #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic push_hi,
  input  logic pop,
  output logic top_valid,
  output logic top_hi
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] lvl;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= '0;
      cnt <= '0;
    end else begin
      case ({push, pop})
        2'b10: if (cnt < CW'(DEPTH)) begin
          lvl <= {lvl[DEPTH-2:0], push_hi};
          cnt <= cnt + 1'b1;
        end
        2'b01: if (cnt != '0) begin
          lvl <= {1'b0, lvl[DEPTH-1:1]};
          cnt <= cnt - 1'b1;
        end
        2'b11: begin
          lvl[0] <= push_hi;
          if (cnt == '0) cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign top_valid = (cnt != '0);
  assign top_hi    = top_valid & lvl[0];

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (cnt < CW'(DEPTH)));
  p_pop_empties_r9: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && cnt == CW'(1)) |=> !top_valid);
endmodule

// File: rtl/vic_ack_ctrl.sv
module vic_ack_ctrl
  import vic_pkg::*;
#(
  parameter logic [15:0] VEC_BASE  = 16'h0003,
  parameter int          VEC_STEP  = 8,
  parameter int          SVC_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cyc_stb,
  input  logic [NRAW-1:0] irq_raw,
  input  logic [NSRC-1:0] src_en,
  input  logic            glb_en,
  input  logic [NSRC-1:0] src_hi,
  input  logic            instr_last,
  input  logic            regs_touch,
  input  logic            reti_exec,
  output logic            call_req,
  output logic [15:0]     vector,
  output logic [NSRC-1:0] ack
);
  ack_st_t         st;
  logic [NSRC-1:0] lat, pend, win_oh, win_q;
  logic            win_hi, win_hi_q, any;
  logic            top_valid, top_hi;
  logic            block_ins, block_lvl, take;
  logic            push, pop;
  logic [15:0]     vec_nx;

  vic_latch u_latch (
    .clk (clk), .rst (rst), .stb (cyc_stb), .raw (irq_raw), .lat (lat)
  );

  assign pend = lat & src_en & {NSRC{glb_en}};

  vic_arb u_arb (
    .pend (pend), .hi (src_hi), .win_oh (win_oh), .win_hi (win_hi), .any (any)
  );

  assign push = cyc_stb && (st == ST_CALL2);
  assign pop  = cyc_stb && reti_exec && instr_last;

  vic_svc #(.DEPTH (SVC_DEPTH)) u_svc (
    .clk (clk), .rst (rst), .push (push), .push_hi (win_hi_q), .pop (pop),
    .top_valid (top_valid), .top_hi (top_hi)
  );

  assign block_ins = instr_last && (regs_touch || reti_exec);
  assign block_lvl = top_valid && (top_hi || !win_hi);
  assign take      = cyc_stb && (st == ST_IDLE) && any && !block_ins && !block_lvl;

  always_comb begin
    vec_nx = '0;
    for (int i = 0; i < NSRC; i++)
      if (win_oh[i]) vec_nx = VEC_BASE + 16'(VEC_STEP * slot_of(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      call_req <= 1'b0;
      vector   <= '0;
      ack      <= '0;
      win_q    <= '0;
      win_hi_q <= 1'b0;
    end else if (cyc_stb) begin
      case (st)
        ST_IDLE: if (take) begin
          st       <= ST_CALL1;
          call_req <= 1'b1;
          vector   <= vec_nx;
          win_q    <= win_oh;
          win_hi_q <= win_hi;
        end
        ST_CALL1: begin
          st  <= ST_CALL2;
          ack <= win_q;
        end
        default: begin
          st       <= ST_IDLE;
          call_req <= 1'b0;
          ack      <= '0;
        end
      endcase
    end
  end

  p_ack_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack));
  p_ack_in_call_r3: assert property (@(posedge clk) disable iff (rst)
    (|ack) |-> call_req);
  p_call_to_ack_r3: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && st == ST_CALL1) |=> (|ack));
  p_vec_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (call_req && !cyc_stb) |=> $stable(vector));
  p_blocked_stays_r8: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && st == ST_IDLE && block_ins) |=> !call_req);
  p_hi_svc_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && st == ST_IDLE && top_hi) |=> !call_req);
endmodule

// File: tb/vic_ack_ctrl_tb.sv
`timescale 1ns/1ps
module vic_ack_ctrl_tb_top;
  localparam int GAP = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_stb = 1'b0;
  logic [6:0]  irq_raw = '0;
  logic [5:0]  src_en = '1;
  logic        glb_en = 1'b1;
  logic [5:0]  src_hi = '0;
  logic        instr_last = 1'b0;
  logic        regs_touch = 1'b0;
  logic        reti_exec = 1'b0;
  logic        call_req;
  logic [15:0] vector;
  logic [5:0]  ack;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  vic_ack_ctrl dut_i (
    .clk (clk), .rst (rst), .cyc_stb (cyc_stb), .irq_raw (irq_raw),
    .src_en (src_en), .glb_en (glb_en), .src_hi (src_hi),
    .instr_last (instr_last), .regs_touch (regs_touch), .reti_exec (reti_exec),
    .call_req (call_req), .vector (vector), .ack (ack)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic mcycle();
    repeat (GAP - 1) @(negedge clk);
    cyc_stb = 1'b1;
    @(negedge clk);
    cyc_stb = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; cyc_stb = 1'b0; irq_raw = '0; src_en = '1; glb_en = 1'b1;
    src_hi = '0; instr_last = 1'b0; regs_touch = 1'b0; reti_exec = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 call_req", 32'(call_req), 0);
    chk("R1 ack", 32'(ack), 0);
    chk("R1 vector", 32'(vector), 0);
    rst = 1'b0;
  endtask

  // full service of one raw flag with timing checks
  task automatic t_serve(input int rbit, input int sidx, input logic [15:0] ev);
    t_reset();
    irq_raw[rbit] = 1'b1;
    mcycle();
    chk("R3 no call after latch strobe", 32'(call_req), 0);
    mcycle();
    chk("R3 call after poll", 32'(call_req), 1);
    chk("R4 vector", 32'(vector), 32'(ev));
    chk("R3 no ack in first call cycle", 32'(ack), 0);
    mcycle();
    chk("R3 call second cycle", 32'(call_req), 1);
    chk("R5 R3 ack source", 32'(ack), 32'(6'b1 << sidx));
    chk("R4 vector held", 32'(vector), 32'(ev));
    irq_raw[rbit] = 1'b0;
    mcycle();
    chk("R3 call ends", 32'(call_req), 0);
    chk("R3 ack ends", 32'(ack), 0);
  endtask

  task automatic t_vectors();
    t_serve(0, 1, 16'h0003);
    t_serve(1, 2, 16'h000B);
    t_serve(2, 3, 16'h0013);
    t_serve(3, 4, 16'h001B);
    t_serve(4, 5, 16'h0023);
    t_serve(5, 5, 16'h0023);
    t_serve(6, 0, 16'h002B);
  endtask

  task automatic t_capture();
    t_reset();
    irq_raw[1] = 1'b1;
    @(negedge clk);
    irq_raw[1] = 1'b0;
    mcycle(); mcycle();
    chk("R2 pulse between strobes ignored", 32'(call_req), 0);
    irq_raw[1] = 1'b1;
    mcycle();
    irq_raw[1] = 1'b0;
    mcycle();
    chk("R2 one-strobe flag taken", 32'(call_req), 1);
    chk("R2 vector", 32'(vector), 32'h000B);
  endtask

  task automatic t_enables();
    t_reset();
    src_en[3] = 1'b0;
    irq_raw[2] = 1'b1;
    mcycle(); mcycle(); mcycle();
    chk("R6 source disabled", 32'(call_req), 0);
    t_reset();
    glb_en = 1'b0;
    irq_raw[2] = 1'b1;
    mcycle(); mcycle(); mcycle();
    chk("R6 global disabled", 32'(call_req), 0);
    glb_en = 1'b1;
    mcycle();
    chk("R6 enable restores", 32'(call_req), 1);
  endtask

  task automatic t_priority();
    t_reset();
    src_hi[4] = 1'b1;
    irq_raw[0] = 1'b1; irq_raw[3] = 1'b1;
    mcycle(); mcycle();
    chk("R7 high level wins", 32'(vector), 32'h001B);
    t_reset();
    irq_raw[0] = 1'b1; irq_raw[2] = 1'b1;
    mcycle(); mcycle();
    chk("R7 ext0 before ext1", 32'(vector), 32'h0003);
    t_reset();
    irq_raw[0] = 1'b1; irq_raw[6] = 1'b1;
    mcycle(); mcycle();
    chk("R7 power-fail first", 32'(vector), 32'h002B);
  endtask

  task automatic t_block();
    t_reset();
    irq_raw[3] = 1'b1;
    mcycle();
    instr_last = 1'b1; regs_touch = 1'b1;
    mcycle();
    chk("R8 register access blocks", 32'(call_req), 0);
    instr_last = 1'b0; regs_touch = 1'b0;
    mcycle();
    chk("R8 repoll takes", 32'(call_req), 1);
    t_reset();
    irq_raw[3] = 1'b1;
    mcycle();
    instr_last = 1'b1; reti_exec = 1'b1;
    mcycle();
    chk("R8 return blocks", 32'(call_req), 0);
    instr_last = 1'b0; reti_exec = 1'b0;
    mcycle();
    chk("R8 repoll after return", 32'(call_req), 1);
  endtask

  task automatic t_nesting();
    t_reset();
    irq_raw[0] = 1'b1;
    mcycle(); mcycle(); mcycle();
    irq_raw[0] = 1'b0;
    mcycle();
    irq_raw[1] = 1'b1;
    mcycle(); mcycle();
    chk("R9 low in service blocks low", 32'(call_req), 0);
    mcycle();
    chk("R9 still blocked", 32'(call_req), 0);
    src_hi[0] = 1'b1; irq_raw[6] = 1'b1;
    mcycle(); mcycle();
    chk("R9 high nests over low", 32'(call_req), 1);
    chk("R9 nested vector", 32'(vector), 32'h002B);
    mcycle();
    chk("R9 nested ack", 32'(ack), 32'h01);
    irq_raw[6] = 1'b0;
    mcycle();
    src_hi[3] = 1'b1; irq_raw[2] = 1'b1;
    mcycle(); mcycle();
    chk("R9 high in service blocks high", 32'(call_req), 0);
    src_hi[3] = 1'b0; irq_raw[2] = 1'b0;
    instr_last = 1'b1; reti_exec = 1'b1;
    mcycle();
    instr_last = 1'b0; reti_exec = 1'b0;
    mcycle();
    chk("R9 low level back on top", 32'(call_req), 0);
    instr_last = 1'b1; reti_exec = 1'b1;
    mcycle();
    instr_last = 1'b0; reti_exec = 1'b0;
    mcycle();
    chk("R9 empty stack takes low", 32'(call_req), 1);
    chk("R9 vector", 32'(vector), 32'h000B);
  endtask

  task automatic t_overlap();
    t_reset();
    irq_raw[2] = 1'b1;
    mcycle(); mcycle();
    chk("R10 first call", 32'(vector), 32'h0013);
    src_hi[0] = 1'b1; irq_raw[6] = 1'b1;
    mcycle();
    chk("R10 ack ext1", 32'(ack), 32'h08);
    irq_raw[2] = 1'b0;
    mcycle();
    chk("R10 gap after call", 32'(call_req), 0);
    mcycle();
    chk("R10 captured during call", 32'(call_req), 1);
    chk("R10 vector", 32'(vector), 32'h002B);
  endtask

  initial begin
    t_reset();
    t_vectors();
    t_capture();
    t_enables();
    t_priority();
    t_block();
    t_nesting();
    t_overlap();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule